// File: doc/BRIEF.md
# Three-Wire Wiper Step Sequencer

This block is a host-side controller for a stepped wiper device driven by three lines: an active-low select, an increment strobe whose falling edge moves the wiper one tap, and a direction line. One command holds a direction, a step count and a commit flag. The block selects the device, waits out the select and direction setup interval, and sends the strobe pulses with the low and high widths given by parameters. It then releases select. With the strobe high, this release commits the position. With the strobe still low from the last pulse, the release leaves the stored value alone. After the release the block waits a recovery interval whose length depends on which kind of release took place, and only then takes the next command.

Every interval is a parameter counted in clock cycles, so one netlist can serve any clock rate. The device has 100 taps and does not move past either end. A requested count above the full travel of 99 steps is therefore clipped. A command with zero steps and the commit flag set selects and releases the device with no pulses, which commits the current position. A command with zero steps and no commit flag does nothing on the lines.

The controller is a single state machine with seven states: IDLE (lines at rest, ready), SETUP (selected, before the first pulse), PULSE_LO and PULSE_HI (the two halves of a strobe pulse), TAIL (strobe high before a committing release), REL_STORE (deselected after a commit, long recovery) and REL_SKIP (deselected with the strobe low, short recovery). Its transitions are as follows:
- IDLE→SETUP on an accepted command that has any work to do.
- SETUP→PULSE_LO, or SETUP→TAIL when the count is zero.
- PULSE_LO→PULSE_HI, or PULSE_LO→REL_SKIP after the last pulse of a command without commit.
- PULSE_HI→PULSE_LO while steps remain, else PULSE_HI→TAIL.
- TAIL→REL_STORE.
- REL_STORE→IDLE and REL_SKIP→IDLE when their timers expire.

Top module: `wiper_seq`

## Requirements
- R1: After reset, and whenever idle, select is high (deselected), strobe is high, ready is 1 and busy is 0.
- R2: A command is taken on a clock edge where valid and ready are both 1. From the next cycle ready is 0 and busy is 1 until the recovery interval ends. Exactly one selection results. A valid raised while busy is ignored.
- R3: Direction (1 = toward the high end) is loaded at acceptance and does not change while select is low. Select is low for exactly T_SETUP cycles before the first strobe falling edge.
- R4: The number of strobe falling edges while select is low equals the requested step count, clipped to MAX_STEPS (99).
- R5: Each strobe low phase lasts T_LOW cycles and each high phase between pulses lasts T_HIGH cycles. The strobe never falls while select is high.
- R6: With the commit flag set, select rises with the strobe high, T_HIGH + T_TAIL cycles after the last strobe rising edge.
- R7: With the commit flag clear, the strobe stays low after the last falling edge. Select rises T_LOW cycles after that edge, and the strobe returns high T_REC_SKIP cycles after select rises.
- R8: Ready returns to 1 exactly T_REC_STORE cycles after a committing release and T_REC_SKIP cycles after a non-committing release.
- R9: A zero-step command with commit holds select low for T_SETUP + T_TAIL cycles, sends no pulses and releases with the strobe high.
- R10: A zero-step command without commit is accepted with no line activity, and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready (idle) |
| cmd_up_i | input | 1 | Direction: 1 toward high end, 0 toward low end |
| cmd_steps_i | input | STEP_W | Requested step count |
| cmd_store_i | input | 1 | Commit position on release |
| sel_n_o | output | 1 | Device select, active low |
| strobe_o | output | 1 | Increment strobe, falling edge steps |
| up_o | output | 1 | Direction line |
| busy_o | output | 1 | Sequence or recovery in progress |

## Verification
A wrong state or a wrong transition shows up on the lines within one phase. A misread remaining-step count changes the number of strobe falling edges seen before select rises. A wrong commit flag appears as the wrong strobe level at the select rising edge. A timer that loads the wrong value shifts the next line edge by a measurable number of cycles. Recovery errors show up as the cycle at which ready reappears. Every edge is therefore checked for its spacing from the previous edge, and ready is checked for the cycle on which it returns.

// File: rtl/wiper_seq_pkg.sv
package wiper_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_TAIL,
        ST_REL_STORE,
        ST_REL_SKIP
    } wseq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wseq_timer.sv
module wseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R5: interval widths depend on a steady countdown
    p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wseq_steps.sv
module wseq_steps #(
    parameter int IN_W      = 7,
    parameter int MAX_STEPS = 99
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [IN_W-1:0] req,
    input  logic            dec,
    output logic            last,
    output logic            empty
);
    localparam int CW = $clog2(MAX_STEPS + 1);

    logic [CW-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= (int'(req) > MAX_STEPS) ? CW'(MAX_STEPS) : CW'(req);
        else if (dec && remaining != '0)
            remaining <= remaining - 1'b1;
    end

    assign last  = (remaining == CW'(1));
    assign empty = (remaining == '0);

    // R4: never more than full travel outstanding
    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(remaining) <= MAX_STEPS);

endmodule

// File: rtl/wiper_seq.sv
module wiper_seq
    import wiper_seq_pkg::*;
#(
    parameter int STEP_W      = 7,
    parameter int MAX_STEPS   = 99,
    parameter int T_SETUP     = 290,
    parameter int T_LOW       = 100,
    parameter int T_HIGH      = 100,
    parameter int T_TAIL      = 100,
    parameter int T_REC_STORE = 2000000,
    parameter int T_REC_SKIP  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_up_i,
    input  logic [STEP_W-1:0] cmd_steps_i,
    input  logic              cmd_store_i,
    output logic              sel_n_o,
    output logic              strobe_o,
    output logic              up_o,
    output logic              busy_o
);
    localparam int unsigned T_MAX = max2(max2(max2(T_SETUP, T_LOW), max2(T_HIGH, T_TAIL)),
                                         max2(T_REC_STORE, T_REC_SKIP));
    localparam int TW = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] V_SETUP = TW'(T_SETUP - 1);
    localparam logic [TW-1:0] V_LOW   = TW'(T_LOW - 1);
    localparam logic [TW-1:0] V_HIGH  = TW'(T_HIGH - 1);
    localparam logic [TW-1:0] V_TAIL  = TW'(T_TAIL - 1);
    localparam logic [TW-1:0] V_STORE = TW'(T_REC_STORE - 1);
    localparam logic [TW-1:0] V_SKIP  = TW'(T_REC_SKIP - 1);

    wseq_state_e   state_q, state_d;
    logic          dir_q, store_q;
    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          s_load, s_dec, s_last, s_empty;
    logic          accept;

    wseq_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .val   (t_val),
        .done  (t_done)
    );

    wseq_steps #(.IN_W(STEP_W), .MAX_STEPS(MAX_STEPS)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (s_load),
        .req   (cmd_steps_i),
        .dec   (s_dec),
        .last  (s_last),
        .empty (s_empty)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            store_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dir_q   <= cmd_up_i;
                store_q <= cmd_store_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        s_load  = 1'b0;
        s_dec   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid_i && (cmd_steps_i != '0 || cmd_store_i)) begin
                    state_d = ST_SETUP;
                    t_load  = 1'b1;
                    t_val   = V_SETUP;
                    s_load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (s_empty) begin
                        state_d = ST_TAIL;
                        t_val   = V_TAIL;
                    end else begin
                        state_d = ST_PULSE_LO;
                        t_val   = V_LOW;
                    end
                end
            end
            ST_PULSE_LO: begin
                if (t_done) begin
                    s_dec  = 1'b1;
                    t_load = 1'b1;
                    if (s_last && !store_q) begin
                        state_d = ST_REL_SKIP;
                        t_val   = V_SKIP;
                    end else begin
                        state_d = ST_PULSE_HI;
                        t_val   = V_HIGH;
                    end
                end
            end
            ST_PULSE_HI: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (s_empty) begin
                        state_d = ST_TAIL;
                        t_val   = V_TAIL;
                    end else begin
                        state_d = ST_PULSE_LO;
                        t_val   = V_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (t_done) begin
                    state_d = ST_REL_STORE;
                    t_load  = 1'b1;
                    t_val   = V_STORE;
                end
            end
            ST_REL_STORE: if (t_done) state_d = ST_IDLE;
            ST_REL_SKIP:  if (t_done) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_n_o     = (state_q == ST_IDLE) || (state_q == ST_REL_STORE) || (state_q == ST_REL_SKIP);
        strobe_o    = !((state_q == ST_PULSE_LO) || (state_q == ST_REL_SKIP));
        cmd_ready_o = (state_q == ST_IDLE);
        busy_o      = (state_q != ST_IDLE);
        up_o        = dir_q;
    end

    // R2: an accepted command with work selects the device next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o && (cmd_steps_i != '0 || cmd_store_i)) |=> (!sel_n_o && busy_o));

    // R3: direction held while selected
    p_dir_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_o && !$past(sel_n_o)) |-> $stable(up_o));

    // R5: strobe falls only while selected
    p_fall_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_o) |-> !sel_n_o);

    // R6: release with strobe high only for a commit
    p_store_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_n_o) && strobe_o) |-> store_q);

    // R7: release with strobe low only without commit
    p_skip_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_n_o) && !strobe_o) |-> !store_q);

endmodule

// File: tb/tb_wiper_seq.sv
module tb_wiper_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T_SU = 4, T_LO = 3, T_HI = 2, T_TL = 5, T_RS = 20, T_RN = 3;
    localparam int MAXS = 99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_up = 1'b0, cmd_store = 1'b0;
    logic [6:0] cmd_steps = '0;
    logic       cmd_ready, sel_n, strobe, up, busy;

    wiper_seq #(
        .STEP_W(7), .MAX_STEPS(MAXS), .T_SETUP(T_SU), .T_LOW(T_LO), .T_HIGH(T_HI),
        .T_TAIL(T_TL), .T_REC_STORE(T_RS), .T_REC_SKIP(T_RN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_up_i(cmd_up), .cmd_steps_i(cmd_steps), .cmd_store_i(cmd_store),
        .sel_n_o(sel_n), .strobe_o(strobe), .up_o(up), .busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clip(int s);
        return (s > MAXS) ? MAXS : s;
    endfunction

    function automatic int rec_len(bit st);
        return st ? T_RS : T_RN;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // line monitor
    logic sel_p = 1'b1, inc_p = 1'b1, dir_p = 1'b0;
    int   run = 0, nfall = 0, sel_falls = 0, rel_cyc = 0;
    bit   obs_store = 0, cur_dir = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sel_n && !sel_p && up !== dir_p)
                chk(0, "R3 direction moved while selected", int'(up), int'(dir_p));
            if (sel_n !== sel_p || strobe !== inc_p) begin
                if (sel_p && !sel_n) begin
                    nfall = 0;
                    sel_falls++;
                    chk(strobe == 1'b1, "R1 strobe high at selection", int'(strobe), 1);
                end else if (!sel_p && !sel_n && inc_p && !strobe) begin
                    if (nfall == 0) chk(run == T_SU, "R3 setup before first fall", run, T_SU);
                    else            chk(run == T_HI, "R5 high phase", run, T_HI);
                    chk(up == cur_dir, "R3 direction", int'(up), int'(cur_dir));
                    nfall++;
                end else if (!sel_p && !sel_n && !inc_p && strobe) begin
                    chk(run == T_LO, "R5 low phase", run, T_LO);
                end else if (!sel_p && sel_n) begin
                    rel_cyc   = cyc;
                    obs_store = strobe;
                    if (strobe) begin
                        if (nfall == 0) chk(run == T_SU + T_TL, "R9 zero-step select width", run, T_SU + T_TL);
                        else            chk(run == T_HI + T_TL, "R6 last rise to release", run, T_HI + T_TL);
                    end else begin
                        chk(run == T_LO, "R7 last fall to release", run, T_LO);
                    end
                end else if (sel_p && sel_n && !inc_p && strobe) begin
                    chk(run == T_RN, "R7 strobe return after release", run, T_RN);
                end else if (sel_p && sel_n && inc_p && !strobe) begin
                    chk(0, "R5 strobe fell while deselected", 0, 1);
                end
                run = 1;
            end else begin
                run++;
            end
        end
        sel_p = sel_n;
        inc_p = strobe;
        dir_p = up;
    end

    task automatic send(bit d, int s, bit st, bit noise);
        int f0;
        int es;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        f0        = sel_falls;
        cur_dir   = d;
        cmd_valid = 1'b1;
        cmd_up    = d;
        cmd_steps = 7'(s);
        cmd_store = st;
        @(negedge clk);
        cmd_valid = 1'b0;
        es = clip(s);
        if (s == 0 && !st) begin
            chk(cmd_ready == 1'b1 && sel_n == 1'b1, "R10 no-op stays idle", int'(cmd_ready), 1);
            repeat (4) @(negedge clk);
            chk(sel_falls == f0, "R10 no selection", sel_falls, f0);
            chk(sel_n == 1'b1 && strobe == 1'b1, "R10 lines at rest", int'(sel_n), 1);
            return;
        end
        chk(busy == 1'b1 && cmd_ready == 1'b0, "R2 busy after accept", int'(busy), 1);
        if (noise) begin
            repeat (3) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_up    = ~d;
            cmd_steps = 7'd7;
            cmd_store = ~st;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(cmd_ready == 1'b1, "R2 ready after recovery", int'(cmd_ready), 1);
        chk(sel_falls == f0 + 1, "R2 one selection per command", sel_falls, f0 + 1);
        chk(nfall == es, "R4 pulse count", nfall, es);
        chk(obs_store == st, "R6 R7 release kind", int'(obs_store), int'(st));
        chk(cyc - rel_cyc == rec_len(st), "R8 recovery length", cyc - rel_cyc, rec_len(st));
        repeat (2) @(negedge clk);
        chk(sel_falls == f0 + 1, "R2 ignored valid started nothing", sel_falls, f0 + 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        chk(sel_n == 1 && strobe == 1 && cmd_ready == 1 && busy == 0, "R1 reset state", int'(sel_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sel_n == 1 && strobe == 1 && cmd_ready == 1 && busy == 0, "R1 idle after reset", int'(busy), 0);

        send(1'b1, 0, 1'b1, 1'b0);   // R9
        send(1'b0, 0, 1'b0, 1'b0);   // R10
        send(1'b1, 1, 1'b1, 1'b0);   // R6
        send(1'b0, 1, 1'b0, 1'b0);   // R7
        send(1'b1, 99, 1'b0, 1'b0);  // R4 full travel
        send(1'b0, 127, 1'b1, 1'b0); // R4 clip
        send(1'b1, 5, 1'b1, 1'b1);   // R2 ignored valid
        send(1'b0, 6, 1'b0, 1'b1);   // R2 ignored valid

        for (int i = 0; i < 30; i++) begin
            send(1'($urandom_range(0, 1)), int'($urandom_range(0, 110)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
        end

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule